// File: doc/BRIEF.md
# Interrupt and Card-Detect Register

This block is one 32-bit control word of a removable-card host controller. It merges four things into a single register: a group of latched event flags, the enable mask for those flags, a live card-present level, and a software-owned activity LED bit. The low half holds the state: event flags, the LED bit and the presence level. The high half holds the enables. Enable bit n+16 gates flag n.

The event sources are the FIFO and DMA logic and a card-detect contact. The sources raise single-cycle pulses. The card contact is asynchronous, so it is synchronized first. Its rising and falling edges become separate insertion and removal flags. Every flag is recorded whether or not it is enabled.

Software clears a flag by writing 0 to its position. Writing 1 leaves the flag as it is. A flag that is enabled and set holds the level interrupt output high until software clears it.

Top module: `cdr_irq_reg`

## Requirements
- R1: After reset, every flag, every enable bit and the LED bit read 0, and `irq_o` is low.
- R2: Bit 1 reads the card-present input after a synchronizer of SYNC_STAGES (default 2) clock edges. Bit 1 is read-only.
- R3: Bit 8 is set one cycle after bit 1 rises (insertion), and bit 9 is set one cycle after bit 1 falls (removal). Both are set even when their enables are 0.
- R4: An input pulse sampled at a clock edge sets its flag at that edge. The mapping is: FIFO-empty to bit 10, DMA-done to bit 11, FIFO-underrun to bit 12, length-mismatch to bit 13, DMA-error to bit 14.
- R5: In a write, a 0 in any of bits 14:8 clears that flag, and a 1 leaves that flag unchanged.
- R6: If an event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R7: A write loads bits 31:16 as the enable mask exactly as written, and the mask reads back unchanged until the next write.
- R8: `irq_o` is high when any flag in bits 14:8 is set while its enable in bits 30:24 is set. It stays high until software clears those flags or their enables.
- R9: Bit 15 is loaded directly by every write, and `led_o` shows its value.
- R10: Bits 7:2 and bit 0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Asynchronous card-detect contact level |
| fifo_empty_i | input | 1 | FIFO-empty event pulse |
| dma_done_i | input | 1 | DMA-complete event pulse |
| dma_err_i | input | 1 | DMA/IO failure event pulse |
| fifo_underrun_i | input | 1 | Software-read-of-empty-FIFO event pulse |
| len_mismatch_i | input | 1 | FIFO count versus command length mismatch pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| irq_o | output | 1 | Level interrupt request |
| led_o | output | 1 | Activity LED drive |

## Verification
All state is visible in `rd_data_o`, so most errors show up in the read word one cycle after the stimulus that caused them.

- A flag dropped by the acknowledge logic, or a flag wrongly kept, shows as a wrong bit on the next read.
- A lost event on a colliding write shows the same way.
- An edge detector facing the wrong direction shows as the wrong bit of 8 and 9, one cycle after bit 1 moves.
- A synchronizer of the wrong depth moves that whole pattern by whole cycles.
- A wrong gate between flag and enable appears on `irq_o` in the same cycle as the read word.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned HALF_W    = REG_W / 2;
  localparam int unsigned POS_PRES  = 1;
  localparam int unsigned POS_INS   = 8;
  localparam int unsigned POS_REM   = 9;
  localparam int unsigned POS_FEMP  = 10;
  localparam int unsigned POS_DDONE = 11;
  localparam int unsigned POS_UNDR  = 12;
  localparam int unsigned POS_MISM  = 13;
  localparam int unsigned POS_DERR  = 14;
  localparam int unsigned POS_LED   = 15;
  localparam int unsigned EV_LO     = POS_INS;
  localparam int unsigned EV_HI     = POS_DERR;
  localparam int unsigned EV_W      = EV_HI - EV_LO + 1;
  typedef logic [EV_W-1:0]   ev_vec_t;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cdr_edge.sv
module cdr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/cdr_evreg.sv
module cdr_evreg
  import cdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_set_i,
  input  logic    wr_en_i,
  input  ev_vec_t wr_flags_i,
  input  logic    wr_led_i,
  input  half_t   wr_en_mask_i,
  output ev_vec_t flags_o,
  output half_t   en_mask_o,
  output logic    led_o
);
  ev_vec_t flags_q, flags_d;
  half_t   en_q, en_d;
  logic    led_q, led_d;

  // Write-zero acknowledge, then OR in the events so they win any collision.
  always_comb begin
    flags_d = flags_q;
    en_d    = en_q;
    led_d   = led_q;
    if (wr_en_i) begin
      flags_d = flags_q & wr_flags_i;
      en_d    = wr_en_mask_i;
      led_d   = wr_led_i;
    end
    flags_d = flags_d | ev_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      led_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      led_q   <= led_d;
    end
  end

  assign flags_o   = flags_q;
  assign en_mask_o = en_q;
  assign led_o     = led_q;
endmodule

// File: rtl/cdr_irq_reg.sv
module cdr_irq_reg
  import cdr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_present_i,
  input  logic              fifo_empty_i,
  input  logic              dma_done_i,
  input  logic              dma_err_i,
  input  logic              fifo_underrun_i,
  input  logic              len_mismatch_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              led_o
);
  logic    present;
  logic    ins_ev, rem_ev;
  ev_vec_t ev_set;
  ev_vec_t flags;
  half_t   en_mask;
  logic    led;
  logic    unused_wr_bits;

  cdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(card_present_i), .q_o(present)
  );

  cdr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(present), .rise_o(ins_ev), .fall_o(rem_ev)
  );

  // Event vector; index k corresponds to register bit EV_LO+k.
  always_comb begin
    ev_set                     = '0;
    ev_set[POS_INS   - EV_LO]  = ins_ev;
    ev_set[POS_REM   - EV_LO]  = rem_ev;
    ev_set[POS_FEMP  - EV_LO]  = fifo_empty_i;
    ev_set[POS_DDONE - EV_LO]  = dma_done_i;
    ev_set[POS_UNDR  - EV_LO]  = fifo_underrun_i;
    ev_set[POS_MISM  - EV_LO]  = len_mismatch_i;
    ev_set[POS_DERR  - EV_LO]  = dma_err_i;
  end

  cdr_evreg u_evreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_set_i     (ev_set),
    .wr_en_i      (wr_en_i),
    .wr_flags_i   (wr_data_i[EV_HI:EV_LO]),
    .wr_led_i     (wr_data_i[POS_LED]),
    .wr_en_mask_i (wr_data_i[REG_W-1:HALF_W]),
    .flags_o      (flags),
    .en_mask_o    (en_mask),
    .led_o        (led)
  );

  assign unused_wr_bits = ^wr_data_i[EV_LO-1:0];

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[POS_PRES]            = present;
    rd_data_o[EV_HI:EV_LO]         = flags;
    rd_data_o[POS_LED]             = led;
    rd_data_o[REG_W-1:HALF_W]      = en_mask;
  end

  assign irq_o = |(flags & en_mask[EV_HI:EV_LO]);
  assign led_o = led;
endmodule

// File: rtl/cdr_irq_reg_chk.sv
module cdr_irq_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dma_done_i,
  input logic        dma_err_i,
  input logic        fifo_underrun_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        irq_o,
  input logic        led_o
);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_en_i) |=> irq_o);

  p_en_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o[31:16]));

  p_en_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[31:16] == $past(wr_data_i[31:16]));

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_i |=> rd_data_o[11]);

  p_derr_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err_i |=> rd_data_o[14]);

  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[12] && !fifo_underrun_i) |=> !rd_data_o[12]);

  p_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_o[1]) |=> rd_data_o[8]);

  p_remove_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data_o[1]) |=> rd_data_o[9]);

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[7:2] == 6'd0) && !rd_data_o[0]);

  p_led_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> led_o == $past(wr_data_i[15]));
endmodule

bind cdr_irq_reg cdr_irq_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_done_i(dma_done_i), .dma_err_i(dma_err_i),
  .fifo_underrun_i(fifo_underrun_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .led_o(led_o)
);

// File: tb/cdr_irq_reg_tb.sv
module cdr_irq_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card = 1'b0;
  logic [4:0]  ev = '0;   // 0 fifo_empty,1 dma_done,2 underrun,3 mismatch,4 dma_err
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq, led;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cdr_irq_reg u_dut (
    .clk(clk), .rst_n(rst_n), .card_present_i(card),
    .fifo_empty_i(ev[0]), .dma_done_i(ev[1]), .fifo_underrun_i(ev[2]),
    .len_mismatch_i(ev[3]), .dma_err_i(ev[4]),
    .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq), .led_o(led)
  );

  // Reference model built from the requirements.
  logic        m_s0, m_s1, m_prev, m_led;
  logic [6:0]  m_stat;
  logic [15:0] m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= 0; m_s1 <= 0; m_prev <= 0; m_stat <= '0; m_en <= '0; m_led <= 0;
    end else begin
      m_s0 <= card; m_s1 <= m_s0; m_prev <= m_s1;
      m_stat <= (wr ? (m_stat & wd[14:8]) : m_stat) | {ev, (~m_s1 & m_prev), (m_s1 & ~m_prev)};
      if (wr) begin m_en <= wd[31:16]; m_led <= wd[15]; end
    end
  end

  function automatic logic [31:0] exp_word();
    return {m_en, m_led, m_stat, 6'b0, m_s1, 1'b0};
  endfunction
  function automatic logic exp_irq();
    return |(m_stat & m_en[14:8]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [31:0] e = exp_word();
    chk(rd[31:16] == e[31:16], "R7", rd, e);
    chk(rd[14:8] == e[14:8], "R5", rd, e);
    chk(rd[1] == e[1], "R2", rd, e);
    chk(led == e[15] && rd[15] == e[15], "R9", {31'd0, led}, {31'd0, e[15]});
    chk(irq == exp_irq(), "R8", {31'd0, irq}, {31'd0, exp_irq()});
    chk(rd[7:2] == 0 && rd[0] == 0, "R10", rd, e);
  endtask

  task automatic cyc(input logic c, input logic [4:0] e, input logic w, input logic [31:0] d);
    card = c; ev = e; wr = w; wd = d;
    @(posedge clk);
    @(negedge clk);
    ev = '0; wr = 1'b0;
    cmp_model();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd == 32'h0, "R1", rd, 32'h0);
    chk(irq == 1'b0, "R1", {31'd0, irq}, 32'h0);

    // Insertion: bit1 after two edges, bit8 one cycle later, not enabled.
    cyc(1, 0, 0, 0);
    chk(rd[1] == 1'b0, "R2", rd, 32'h0);
    cyc(1, 0, 0, 0);
    chk(rd == 32'h2, "R2", rd, 32'h2);
    cyc(1, 0, 0, 0);
    chk(rd == 32'h102, "R3", rd, 32'h102);
    chk(irq == 1'b0, "R3", {31'd0, irq}, 32'h0);

    cyc(1, 0, 1, 32'h7F00_7F00);
    chk(rd == 32'h7F00_0102 && irq, "R8", rd, 32'h7F00_0102);
    cyc(1, 0, 0, 0);
    chk(irq == 1'b1, "R8", {31'd0, irq}, 32'h1);
    cyc(1, 0, 1, 32'h7F00_7E00);
    chk(rd == 32'h7F00_0002 && !irq, "R5", rd, 32'h7F00_0002);
    cyc(1, 5'b00010, 1, 32'h7F00_7700);
    chk(rd == 32'h7F00_0802 && irq, "R6", rd, 32'h7F00_0802);
    cyc(1, 0, 1, 32'h7F00_7FFF);
    chk(rd == 32'h7F00_0802, "R5", rd, 32'h7F00_0802);
    chk(rd[7:0] == 8'h02, "R10", rd, 32'h7F00_0802);
    cyc(1, 0, 1, 32'h7F00_F7FF);
    chk(rd == 32'h7F00_8002 && led && !irq, "R9", rd, 32'h7F00_8002);
    cyc(1, 0, 1, 32'h0);
    chk(rd == 32'h2 && !led, "R9", rd, 32'h2);

    for (int k = 0; k < 5; k++) begin
      cyc(1, 5'(1 << k), 0, 0);
      chk(rd == (32'h2 | (32'h1 << (10 + k))), "R4", rd, 32'h2 | (32'h1 << (10 + k)));
      cyc(1, 0, 1, 32'h0);
      chk(rd == 32'h2, "R5", rd, 32'h2);
    end

    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(rd == 32'h0, "R2", rd, 32'h0);
    cyc(0, 0, 0, 0);
    chk(rd == 32'h200, "R3", rd, 32'h200);
    cyc(0, 0, 1, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic       c = card;
      logic [4:0] e = '0;
      if (($urandom % 16) == 0) c = ~c;
      for (int b = 0; b < 5; b++) e[b] = (($urandom % 8) == 0);
      cyc(c, e, (($urandom % 4) == 0), $urandom);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule